// File: doc/BRIEF.md
# Fixed-Point Multiply Stage with Word Overflow

This block is the multiply step of a 64-bit processor's fixed-point unit. Each accepted request carries two 64-bit operands, a two-bit operation code and two qualifiers, `in_is_32bit` and `in_is_signed`. The operation code picks the low 64 bits of the product, the signed upper 64 bits, or the unsigned upper 64 bits. The qualifiers only affect the low operation. They choose between the full 64-bit operands and the lower 32-bit words, and between signed and unsigned word products.

Signed products are formed by multiplying operand magnitudes as unsigned values. The full product is negated when the two operand signs differ. In 32-bit low mode the block also flags a result that cannot be represented as a sign-extended 32-bit value, and it drives that flag onto both overflow bits. Carry and condition updates are not produced here. Overflow for the 64-bit low operation is not computed and stays zero.

A request is taken on any rising edge where `in_valid` is high. The result and overflow appear on the registered outputs on the next cycle, together with `out_valid`. When no request is taken, the registered result holds its last value.

Top module: `mul_stage`

## Requirements
- R1: While synchronous active-high reset `rst` is asserted, and on the first cycle after it, `out_valid` is 0 and `out_result` and `out_ov` read 0.
- R2: `out_valid` is high exactly in the cycle after an edge that sampled `in_valid` high. On an edge where `in_valid` is low, `out_result` and `out_ov` keep their values.
- R3: With `in_op` = 2'b00 and `in_is_32bit` = 0, `out_result` is bits 63:0 of the product of the operands. The value is the same whether `in_is_signed` is 0 or 1.
- R4: With `in_op` = 2'b01, `out_result` is bits 127:64 of the 128-bit product of the operands taken as two's-complement values.
- R5: With `in_op` = 2'b10, `out_result` is bits 127:64 of the unsigned 128-bit product of the operands.
- R6: With `in_op` = 2'b00, `in_is_32bit` = 1 and `in_is_signed` = 0, `out_result` is the unsigned product of operand bits 31:0, zero-extended to 64 bits. Operand bits 63:32 are ignored.
- R7: With `in_op` = 2'b00, `in_is_32bit` = 1 and `in_is_signed` = 1, `out_result` is the 64-bit two's-complement product of operand bits 31:0, with bit 31 of each operand taken as its sign. Operand bits 63:32 are ignored.
- R8: In 32-bit low mode (`in_op` = 2'b00, `in_is_32bit` = 1), both bits of `out_ov` are 1 when bits 63:31 of `out_result` are not all equal, and both are 0 otherwise.
- R9: For any request not in 32-bit low mode, `out_ov` is 2'b00. Operation code 2'b11 is reserved and gives a zero result.
- R10: The two high operations (2'b01, 2'b10) ignore `in_is_32bit` and `in_is_signed`.
- R11: Most-negative operands (0x8000_0000 in word mode, 0x8000_0000_0000_0000 in doubleword mode) produce arithmetically correct products. Their magnitude is treated as an unsigned value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request accepted on this edge when high |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| in_op | input | 2 | 00 low half, 01 signed high half, 10 unsigned high half, 11 reserved |
| in_is_32bit | input | 1 | Low operation on operand bits 31:0 |
| in_is_signed | input | 1 | Low operation treats operands as two's complement |
| out_valid | output | 1 | Registered result is new this cycle |
| out_result | output | 64 | Registered product result |
| out_ov | output | 2 | Registered overflow, same value on both bits |

## Verification
On every cycle, the embedded assertions check the following:
- `out_valid` tracks the previous cycle's accepted request, and the result holds when no request was taken.
- The two overflow bits always agree.
- The unsigned high operation never requests negation.
- A word-mode signed product with a nonzero magnitude and differing signs comes out negative.

The arithmetic values themselves can only be shown by the bench's scenarios. These compare each mode against a reference built from sign-extended and zero-extended multiplication. The operands include 0, 1, -1, the most-negative word and doubleword values, operands whose upper halves hold junk, and the reserved operation code.

// File: rtl/mulstg_pkg.sv
package mulstg_pkg;

    parameter int unsigned XLEN = 64;
    localparam int unsigned HALF = XLEN / 2;
    localparam int unsigned PLEN = 2 * XLEN;

    typedef enum logic [1:0] {
        MOP_LOW    = 2'b00,
        MOP_HIGH_S = 2'b01,
        MOP_HIGH_U = 2'b10,
        MOP_RSVD   = 2'b11
    } mop_e;

    typedef struct packed {
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        mop_e            op;
        logic            is_32;
        logic            is_signed;
    } mreq_t;

    typedef struct packed {
        logic [XLEN-1:0] mag_a;
        logic [XLEN-1:0] mag_b;
        logic            negate;
    } mprep_t;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic [1:0]      ov;
    } mres_t;

    // Two's-complement magnitude when flip is set, value unchanged otherwise.
    function automatic logic [XLEN-1:0] cond_abs(input logic [XLEN-1:0] v, input logic flip);
        return flip ? (~v + {{(XLEN-1){1'b0}}, 1'b1}) : v;
    endfunction

    // Keep only the lower word, zero above it.
    function automatic logic [XLEN-1:0] keep_low_word(input logic [XLEN-1:0] v);
        return {{HALF{1'b0}}, v[HALF-1:0]};
    endfunction

    // True when bits [XLEN-1:HALF-1] are not a pure sign extension.
    function automatic logic word_overflow(input logic [XLEN-1:0] r);
        logic [HALF:0] upper;
        upper = r[XLEN-1:HALF-1];
        return (|upper) && !(&upper);
    endfunction

endpackage

// File: rtl/mul_operand_prep.sv
module mul_operand_prep
    import mulstg_pkg::*;
(
    input  mreq_t  req,
    output mprep_t prep
);
    localparam int unsigned NOPS = 2;

    logic                 word_mode;
    logic                 use_sign;
    logic [NOPS-1:0]      sign_bit;
    logic [NOPS-1:0][XLEN-1:0] raw;
    logic [NOPS-1:0][XLEN-1:0] mag;

    assign word_mode = (req.op == MOP_LOW) && req.is_32;
    assign use_sign  = (req.op == MOP_HIGH_S) || ((req.op == MOP_LOW) && req.is_signed);
    assign raw[0]    = req.a;
    assign raw[1]    = req.b;

    for (genvar i = 0; i < NOPS; i++) begin : g_opnd
        assign sign_bit[i] = word_mode ? raw[i][HALF-1] : raw[i][XLEN-1];
        always_comb begin
            logic [XLEN-1:0] m;
            m = cond_abs(raw[i], use_sign && sign_bit[i]);
            mag[i] = word_mode ? keep_low_word(m) : m;
        end
    end

    assign prep.mag_a  = mag[0];
    assign prep.mag_b  = mag[1];
    assign prep.negate = use_sign && (sign_bit[0] ^ sign_bit[1]);

endmodule

// File: rtl/mul_core.sv
module mul_core #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-1:0] p
);
    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] x_ext;
    logic [PW-1:0] y_ext;

    assign x_ext = {{W{1'b0}}, x};
    assign y_ext = {{W{1'b0}}, y};
    assign p     = x_ext * y_ext;

endmodule

// File: rtl/mul_result_fmt.sv
module mul_result_fmt
    import mulstg_pkg::*;
(
    input  mreq_t           req,
    input  logic            negate,
    input  logic [PLEN-1:0] prod,
    output mres_t           res
);
    logic [PLEN-1:0] signed_prod;
    logic            word_mode;

    assign signed_prod = negate ? (~prod + {{(PLEN-1){1'b0}}, 1'b1}) : prod;
    assign word_mode   = (req.op == MOP_LOW) && req.is_32;

    always_comb begin
        res = '0;
        unique case (req.op)
            MOP_LOW: begin
                res.result = signed_prod[XLEN-1:0];
                if (req.is_32) begin
                    res.ov = {2{word_overflow(signed_prod[XLEN-1:0])}};
                end
            end
            MOP_HIGH_S, MOP_HIGH_U: res.result = signed_prod[PLEN-1:XLEN];
            default:                res = '0;
        endcase
    end

    always_comb begin
        AST_HIGHU_NO_NEGATE: assert (!(req.op == MOP_HIGH_U) || !negate); // R5
        AST_WORD_SIGN: assert (!(word_mode && req.is_signed && negate && (prod != '0))
                               || res.result[XLEN-1]); // R7
    end

endmodule

// File: rtl/mul_stage.sv
module mul_stage
    import mulstg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [XLEN-1:0] in_a,
    input  logic [XLEN-1:0] in_b,
    input  logic [1:0]      in_op,
    input  logic            in_is_32bit,
    input  logic            in_is_signed,
    output logic            out_valid,
    output logic [XLEN-1:0] out_result,
    output logic [1:0]      out_ov
);
    mreq_t           req;
    mprep_t          prep;
    logic [PLEN-1:0] prod;
    mres_t           res_d;
    mres_t           res_q;
    logic            valid_q;

    assign req.a         = in_a;
    assign req.b         = in_b;
    assign req.op        = mop_e'(in_op);
    assign req.is_32     = in_is_32bit;
    assign req.is_signed = in_is_signed;

    mul_operand_prep u_prep (
        .req  (req),
        .prep (prep)
    );

    mul_core #(.W(XLEN)) u_core (
        .x (prep.mag_a),
        .y (prep.mag_b),
        .p (prod)
    );

    mul_result_fmt u_fmt (
        .req    (req),
        .negate (prep.negate),
        .prod   (prod),
        .res    (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign out_valid  = valid_q;
    assign out_result = res_q.result;
    assign out_ov     = res_q.ov;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid && !rst)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(in_valid) && !$past(rst)) |-> ($stable(out_result) && $stable(out_ov))); // R2
    AST_OV_PAIR: assert property (@(posedge clk) disable iff (rst)
        out_ov[0] == out_ov[1]); // R8
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_result == '0)); // R1

endmodule

// File: tb/mul_stage_bench.sv
`timescale 1ns/1ps
module mul_stage_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic [1:0]  in_op = '0;
    logic        in_is_32bit = 1'b0;
    logic        in_is_signed = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic [1:0]  out_ov;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;
    localparam logic [63:0] NEG1  = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MIN32 = 64'h0000_0000_8000_0000;

    always #2 clk = ~clk;

    mul_stage u_mul_stage (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_a         (in_a),
        .in_b         (in_b),
        .in_op        (in_op),
        .in_is_32bit  (in_is_32bit),
        .in_is_signed (in_is_signed),
        .out_valid    (out_valid),
        .out_result   (out_result),
        .out_ov       (out_ov)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model from extended multiplication, independent of the design.
    function automatic logic [65:0] ref_calc(input logic [63:0] a, input logic [63:0] b,
                                             input logic [1:0] op, input logic w, input logic s);
        logic [127:0] p;
        logic [63:0]  r;
        logic [1:0]   ov;
        ov = 2'b00;
        case (op)
            2'b00: begin
                if (w) begin
                    logic [63:0] ea, eb;
                    ea = s ? {{32{a[31]}}, a[31:0]} : {32'h0, a[31:0]};
                    eb = s ? {{32{b[31]}}, b[31:0]} : {32'h0, b[31:0]};
                    r  = ea * eb;
                    if (r[63:31] != '0 && r[63:31] != {33{1'b1}}) ov = 2'b11;
                end else begin
                    r = a * b;
                end
            end
            2'b01: begin
                p = {{64{a[63]}}, a} * {{64{b[63]}}, b};
                r = p[127:64];
            end
            2'b10: begin
                p = {64'h0, a} * {64'h0, b};
                r = p[127:64];
            end
            default: r = '0;
        endcase
        return {ov, r};
    endfunction

    task automatic run_op(input string tag, input logic [63:0] a, input logic [63:0] b,
                          input logic [1:0] op, input logic w, input logic s);
        logic [65:0] e;
        e = ref_calc(a, b, op, w, s);
        @(negedge clk);
        in_valid = 1'b1; in_a = a; in_b = b; in_op = op; in_is_32bit = w; in_is_signed = s;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " valid"}, {63'h0, out_valid}, 64'h1);
        chk({tag, " result"}, out_result, e[63:0]);
        chk({tag, " ov"}, {62'h0, out_ov}, {62'h0, e[65:64]});
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset valid", {63'h0, out_valid}, 64'h0);
        chk("R1 reset result", out_result, 64'h0);
        chk("R1 reset ov", {62'h0, out_ov}, 64'h0);
    endtask

    task automatic t_low64();
        run_op("R3 low64 u", 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 2'b00, 1'b0, 1'b0);
        run_op("R3 low64 s", 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 2'b00, 1'b0, 1'b1);
        run_op("R3 low64 neg", NEG1, 64'd7, 2'b00, 1'b0, 1'b1);
        run_op("R3 low64 zero", 64'd0, NEG1, 2'b00, 1'b0, 1'b0);
    endtask

    task automatic t_high_signed();
        run_op("R4 hs -1*-1", NEG1, NEG1, 2'b01, 1'b0, 1'b0);
        run_op("R4 hs -1*1", NEG1, 64'd1, 2'b01, 1'b0, 1'b0);
        run_op("R4 hs mix", 64'hDEAD_BEEF_0000_1111, 64'h7FFF_0000_FFFF_0001, 2'b01, 1'b0, 1'b0);
        run_op("R11 hs min*min", MIN64, MIN64, 2'b01, 1'b0, 1'b0);
        run_op("R11 hs min*-1", MIN64, NEG1, 2'b01, 1'b0, 1'b0);
    endtask

    task automatic t_high_unsigned();
        run_op("R5 hu -1*-1", NEG1, NEG1, 2'b10, 1'b0, 1'b0);
        run_op("R5 hu min*2", MIN64, 64'd2, 2'b10, 1'b0, 1'b0);
        run_op("R5 hu mix", 64'hDEAD_BEEF_0000_1111, 64'h7FFF_0000_FFFF_0001, 2'b10, 1'b0, 1'b0);
    endtask

    task automatic t_word_unsigned();
        run_op("R6 w u max", 64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_FFFF_FFFF, 2'b00, 1'b1, 1'b0);
        run_op("R6 w u small", 64'hFFFF_0000_0000_0003, 64'h1234_0000_0000_0005, 2'b00, 1'b1, 1'b0);
        run_op("R6 w u min", MIN32, MIN32, 2'b00, 1'b1, 1'b0);
    endtask

    task automatic t_word_signed();
        run_op("R7 w s -1*-1", NEG1, NEG1, 2'b00, 1'b1, 1'b1);
        run_op("R7 w s -1*5 junk", 64'h1111_2222_FFFF_FFFF, 64'hABCD_0000_0000_0005, 2'b00, 1'b1, 1'b1);
        run_op("R11 w s min*min", MIN32, MIN32, 2'b00, 1'b1, 1'b1);
        run_op("R11 w s min*-1", MIN32, NEG1, 2'b00, 1'b1, 1'b1);
        run_op("R11 w s min*1", MIN32, 64'd1, 2'b00, 1'b1, 1'b1);
    endtask

    task automatic t_overflow();
        // 0x10000 * 0x8000 = 0x8000_0000: bit 31 set, bit 63 clear -> flagged
        run_op("R8 ov edge", 64'h0001_0000, 64'h0000_8000, 2'b00, 1'b1, 1'b1);
        chk("R8 ov set", {62'h0, out_ov}, 64'h3);
        // 0x10000 * 0x7FFF fits below bit 31 -> clear
        run_op("R8 ov fits", 64'h0001_0000, 64'h0000_7FFF, 2'b00, 1'b1, 1'b1);
        chk("R8 ov clear", {62'h0, out_ov}, 64'h0);
        // -0x10000 * 0x8000 = -0x8000_0000 -> representable
        run_op("R8 ov neg fits", 64'hFFFF_0000, 64'h0000_8000, 2'b00, 1'b1, 1'b1);
        chk("R8 ov neg clear", {62'h0, out_ov}, 64'h0);
    endtask

    task automatic t_no_ov_elsewhere();
        run_op("R9 low64 no ov", NEG1, NEG1, 2'b00, 1'b0, 1'b0);
        chk("R9 low64 ov zero", {62'h0, out_ov}, 64'h0);
        run_op("R9 rsvd", NEG1, NEG1, 2'b11, 1'b1, 1'b1);
        chk("R9 rsvd zero", out_result, 64'h0);
    endtask

    task automatic t_high_qualifiers();
        logic [63:0] base;
        run_op("R10 hs base", MIN64, 64'h0000_0003_0000_0007, 2'b01, 1'b0, 1'b0);
        base = out_result;
        run_op("R10 hs quals", MIN64, 64'h0000_0003_0000_0007, 2'b01, 1'b1, 1'b1);
        chk("R10 hs same", out_result, base);
        run_op("R10 hu base", NEG1, 64'h0000_0003_0000_0007, 2'b10, 1'b0, 1'b0);
        base = out_result;
        run_op("R10 hu quals", NEG1, 64'h0000_0003_0000_0007, 2'b10, 1'b1, 1'b1);
        chk("R10 hu same", out_result, base);
    endtask

    task automatic t_hold();
        logic [63:0] held;
        run_op("R2 hold setup", 64'd6, 64'd7, 2'b00, 1'b0, 1'b0);
        held = out_result;
        @(negedge clk);
        in_a = 64'd99; in_b = 64'd99; in_op = 2'b10;
        @(negedge clk);
        chk("R2 idle valid", {63'h0, out_valid}, 64'h0);
        chk("R2 idle hold", out_result, held);
    endtask

    task automatic t_random();
        for (int i = 0; i < 200; i++) begin
            logic [63:0] a, b;
            logic [1:0]  op;
            a  = {$urandom, $urandom};
            b  = {$urandom, $urandom};
            op = 2'($urandom_range(0, 3));
            run_op("R3-7 random", a, b, op, 1'($urandom), 1'($urandom));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_low64();
        t_high_signed();
        t_high_unsigned();
        t_word_unsigned();
        t_word_signed();
        t_overflow();
        t_no_ov_elsewhere();
        t_high_qualifiers();
        t_hold();
        t_random();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule